// File: doc/BRIEF.md
# Disk Change Status Flag

This block keeps the drive-side "medium may have changed" status bit of a floppy drive interface. The flag is raised at power-up and whenever the disk-present sensor reports no medium. It drops only once a disk is present and the host issues a head step pulse while this drive is selected. A disk insertion on its own never drops it. The host reads the flag to decide whether it must re-read the directory of the medium.

The disk-present and step inputs come from the outside world and pass through two-flop synchronisers. The step line is active low, and the block acts on its trailing (rising) edge. A one-bit configuration input picks which of two connector pins carries the active-low flag. One of those pins is shared with the active-low ready status. All responses are a few cycles long, well inside one microsecond at the intended clock rates.

Top module: `dchg_status`

## Requirements
- R1: While `rst_n` is low, and after it is released, the flag is asserted (the pin carrying it reads 0).
- R2: When `disk_present` is low, the flag is set no later than the third rising clock edge after the input change, and it stays set while no disk is present.
- R3: With `disk_present` high and `drv_sel` high, a trailing edge of `step_n` (a 0-to-1 transition) clears the flag. The clear happens at the third rising clock edge after `step_n` rises.
- R4: Inserting a disk (`disk_present` going high) without a qualifying step leaves the flag set.
- R5: A step pulse while `drv_sel` is low leaves the flag unchanged.
- R6: The leading (falling) edge of `step_n` has no effect. Holding `step_n` low keeps the flag set until the line returns high.
- R7: A step pulse while no disk is present leaves the flag set. If removal and a clear coincide, removal wins.
- R8: With `pin_sel`=0, `pin_b_n` carries the active-low flag and `pin_a_n` carries `ready_n`. With `pin_sel`=1, `pin_a_n` carries the active-low flag and `pin_b_n` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| disk_present | input | 1 | Medium sensor, high when a disk is seated (asynchronous) |
| drv_sel | input | 1 | Decoded drive select, high when this drive is addressed (synchronous) |
| step_n | input | 1 | Head step pulse, active low (asynchronous) |
| ready_n | input | 1 | Active-low ready status to share the connector pin |
| pin_sel | input | 1 | 0: flag on pin B; 1: flag on pin A |
| pin_a_n | output | 1 | Shared connector pin (ready or flag) |
| pin_b_n | output | 1 | Dedicated connector pin (flag or idle high) |

## Verification
On every cycle, the assertions check four things. A missing disk forces the flag set on the next edge. A qualified step edge clears it. Any fall or rise of the flag is preceded by its legal cause. A detected step edge lasts a single cycle. The bench scenarios are the only evidence for several points: the exact three-edge latency from the pins, that insertion alone or an unselected step changes nothing, that a held-low step does nothing until release, and the pin routing under both settings of the select.

// File: rtl/dchg_pkg.sv
package dchg_pkg;
  typedef enum logic {
    ROUTE_DEDICATED = 1'b0,
    ROUTE_SHARED    = 1'b1
  } route_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/dchg_sync.sv
module dchg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] nxt;
      if (g == 0) begin : g_first
        always_comb nxt = d_in;
      end else begin : g_rest
        always_comb nxt = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= nxt;
      end
    end
  endgenerate

  assign d_out = chain_q[LAST];
endmodule

// File: rtl/dchg_rise.sv
module dchg_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/dchg_flag.sv
module dchg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic disk_ok,
  input  logic sel,
  input  logic step_rise,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic set_req;
  logic clr_req;
  logic upd_en;

  always_comb begin
    set_req = ~disk_ok;
    clr_req = step_rise & sel & disk_ok;
    upd_en  = set_req | clr_req;
    flag_d  = flag_q;
    if (set_req)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b1;
    else if (upd_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_NO_DISK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !disk_ok |=> flag); // R2
  AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && sel && disk_ok) |=> !flag); // R3
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(step_rise && sel && disk_ok)); // R5
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(!disk_ok)); // R7
endmodule

// File: rtl/dchg_status.sv
module dchg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic disk_present,
  input  logic drv_sel,
  input  logic step_n,
  input  logic ready_n,
  input  logic pin_sel,
  output logic pin_a_n,
  output logic pin_b_n
);
  import dchg_pkg::*;

  logic [1:0] raw_in;
  logic [1:0] sync_out;
  logic disk_s;
  logic step_s;
  logic step_rise;
  logic flag;
  route_e route;

  assign raw_in = {disk_present, step_n};

  dchg_sync #(
    .STAGES (SYNC_DEPTH),
    .WIDTH  (2),
    .RST_VAL(2'b01)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (raw_in),
    .d_out(sync_out)
  );

  assign disk_s = sync_out[1];
  assign step_s = sync_out[0];

  dchg_rise u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (step_s),
    .rise (step_rise)
  );

  dchg_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .disk_ok  (disk_s),
    .sel      (drv_sel),
    .step_rise(step_rise),
    .flag     (flag)
  );

  always_comb begin
    route = route_e'(pin_sel);
    unique case (route)
      ROUTE_SHARED: begin
        pin_a_n = ~flag;
        pin_b_n = 1'b1;
      end
      default: begin
        pin_a_n = ready_n;
        pin_b_n = ~flag;
      end
    endcase
  end

  AST_SHARED_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel |-> pin_b_n); // R8
endmodule

// File: tb/dchg_status_test.sv
`timescale 1ns/1ps
module dchg_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disk_present = 1'b0;
  logic drv_sel = 1'b0;
  logic step_n = 1'b1;
  logic ready_n = 1'b1;
  logic pin_sel = 1'b0;
  logic pin_a_n;
  logic pin_b_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dchg_status uut (
    .clk(clk), .rst_n(rst_n), .disk_present(disk_present), .drv_sel(drv_sel),
    .step_n(step_n), .ready_n(ready_n), .pin_sel(pin_sel),
    .pin_a_n(pin_a_n), .pin_b_n(pin_b_n)
  );

  // {disk, sel, do_step, pin_sel, ready_n, exp_a, exp_b}
  localparam int NV = 7;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_0_1_0_1_1_0, // R7: step with no disk, flag stays set
    7'b1_0_1_0_0_0_0, // R5: unselected step, flag stays set (disk bit below)
    7'b1_1_0_0_1_1_0, // R4: insertion without step keeps flag
    7'b1_1_1_0_1_1_1, // R3: qualified step clears
    7'b1_1_0_1_0_1_1, // R8: shared routing, flag clear
    7'b0_0_0_1_0_0_1, // R2: removal sets flag, shared routing
    7'b1_1_1_1_1_1_1  // R3: clear again in shared routing
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_step();
    @(negedge clk) step_n = 1'b0;
    wait_neg(3);
    step_n = 1'b1;
    wait_neg(5);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    wait_neg(3);
    check("R1", pin_b_n, 1'b0, "flag during reset");
    check("R1", pin_a_n, 1'b1, "pin A follows ready during reset");
    rst_n = 1'b1;
    wait_neg(4);
    check("R1", pin_b_n, 1'b0, "flag after reset");

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [6:0] w;
      w = VEC[v];
      @(negedge clk);
      disk_present = (v == 0) ? 1'b0 : w[6];
      drv_sel = (v == 0) ? 1'b1 : w[5];
      pin_sel = w[3];
      ready_n = w[2];
      wait_neg(5);
      if (w[4]) pulse_step();
      check("R2-R8 vector", pin_a_n, w[1], $sformatf("vector %0d pin A", v));
      check("R2-R8 vector", pin_b_n, w[0], $sformatf("vector %0d pin B", v));
    end

    // R2: removal latency, dedicated routing
    @(negedge clk) pin_sel = 1'b0; disk_present = 1'b1; drv_sel = 1'b1;
    wait_neg(5);
    check("R2", pin_b_n, 1'b1, "flag clear before removal");
    disk_present = 1'b0;
    wait_neg(2);
    check("R2", pin_b_n, 1'b1, "flag not yet set after two edges");
    wait_neg(1);
    check("R2", pin_b_n, 1'b0, "flag set at third edge after removal");

    // R4 again: insertion alone
    disk_present = 1'b1;
    wait_neg(8);
    check("R4", pin_b_n, 1'b0, "insertion alone keeps flag");

    // R6: leading edge and held-low step do nothing
    step_n = 1'b0;
    wait_neg(8);
    check("R6", pin_b_n, 1'b0, "held-low step keeps flag");
    // R3: exact clear latency after trailing edge
    step_n = 1'b1;
    wait_neg(2);
    check("R3", pin_b_n, 1'b0, "not cleared two edges after rise");
    wait_neg(1);
    check("R3", pin_b_n, 1'b1, "cleared at third edge after rise");

    // R7: removal during step trailing edge -> removal wins
    @(negedge clk) step_n = 1'b0;
    wait_neg(3);
    disk_present = 1'b0;
    step_n = 1'b1;
    wait_neg(6);
    check("R7", pin_b_n, 1'b0, "removal beats coincident step");

    // R1: reset mid-operation re-asserts flag
    disk_present = 1'b1;
    pulse_step();
    check("R3", pin_b_n, 1'b1, "cleared before reset");
    rst_n = 1'b0;
    wait_neg(1);
    check("R1", pin_b_n, 1'b0, "reset re-asserts flag");
    rst_n = 1'b1;
    wait_neg(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule